// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

The block gathers three event sources (watchdog expiry, alarm match and power failure) into sticky status flags and a single interrupt pin. Each event always records itself in its own flag. The event reaches the pin only when its source enable is set. Software reads the flag register, and the read also clears it. An event that lands in the same cycle as the read is kept.

Two control bits shape the pin. The mode bit chooses between a level that holds while an enabled flag is pending and a timed pulse. The pulse length is set in clock cycles by a parameter, roughly 200 ms of wall time. The polarity bit chooses between a pin driven actively high and an emulated open-drain, active-low pin, given as a data value plus an output enable. Detecting the events themselves is left to other logic.

Top module: `irq_pin_ctrl`

## Requirements
- R1: An event on any source sets that source's flag on the next clock edge, whatever the state of its enable bit. The flag bits are bit 0 watchdog, bit 1 alarm and bit 2 power-fail.
- R2: A flags read (flags_rd_i high for one cycle) sees the current flags and clears them at the next edge. An event arriving in the read cycle leaves its flag set.
- R3: A source whose enable bit is 0 changes only its flag. The pin stays inactive.
- R4: In level mode (control bit 4 = 0) the pin is active exactly while some flag has its enable bit set. It goes inactive once a read clears those flags.
- R5: In pulse mode (control bit 4 = 1) an enabled event makes the pin active from the next cycle for PULSE_CYCLES cycles.
- R6: In pulse mode an enabled event during a pulse restarts the full PULSE_CYCLES count.
- R7: With the polarity bit (control bit 3) at 1, irq_oe_o is always 1 and irq_o is 1 when active, 0 when inactive.
- R8: With the polarity bit at 0, irq_o is always 0, and irq_oe_o is 1 when active and 0 when inactive (released).
- R9: Reset clears the flags, the enables and the mode bits, so the pin is released (irq_oe_o = 0).
- R10: The control register takes ctrl_wdata_i on a cycle with ctrl_we_i high and reads back on ctrl_rdata_o from the next cycle. Its bits are: [0] watchdog enable, [1] alarm enable, [2] power-fail enable, [3] polarity, [4] pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_wdog_i | input | 1 | Watchdog expiry event, one cycle |
| evt_alarm_i | input | 1 | Alarm match event, one cycle |
| evt_pwr_i | input | 1 | Power-fail event, one cycle |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control register write data |
| ctrl_rdata_o | output | 5 | Control register contents |
| flags_rd_i | input | 1 | Flags read strobe (read clears) |
| flags_o | output | 3 | Current status flags |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The properties assume the event inputs and strobes are sampled once per clock and that any pulse-mode check is made in a cycle with no control write, because a write in that cycle may change the mode. The bench drives every input at the falling edge and keeps event pulses to single cycles. It exercises writes coinciding with events only in the randomized phase, where the cycle-level model covers them and the guarded properties stand aside. It uses a short pulse length so that expiry, retriggering in the middle of a pulse, reads that coincide with events, and switching polarity both during a pulse and at rest are all reached.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_WDOG  = 0;
  localparam int SRC_ALARM = 1;
  localparam int SRC_PWR   = 2;
  localparam int CTRL_W = NUM_SRC + 2;

  typedef struct packed {
    logic               pulse_mode;
    logic               active_high;
    logic [NUM_SRC-1:0] src_en;
  } irq_ctrl_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[g] <= 1'b0;
      else if (evt_i[g])  flags_o[g] <= 1'b1;  // event wins over clear
      else if (clr_i)     flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive (
  input  logic active_i,
  input  logic active_high_i,
  output logic pin_o,
  output logic pin_oe_o
);
  always_comb begin
    if (active_high_i) begin
      pin_o    = active_i;
      pin_oe_o = 1'b1;
    end else begin
      pin_o    = 1'b0;      // open drain: only ever pulls low
      pin_oe_o = active_i;
    end
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int PULSE_CYCLES = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_wdog_i,
  input  logic              evt_alarm_i,
  input  logic              evt_pwr_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              flags_rd_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  irq_ctrl_t          ctrl_q;
  logic [NUM_SRC-1:0] evt;
  logic               level_act, pulse_act, pulse_trig, pin_act;

  always_comb begin
    evt = '0;
    evt[SRC_WDOG]  = evt_wdog_i;
    evt[SRC_ALARM] = evt_alarm_i;
    evt[SRC_PWR]   = evt_pwr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= irq_ctrl_t'(ctrl_wdata_i);
  end
  assign ctrl_rdata_o = ctrl_q;

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (flags_rd_i),
    .flags_o (flags_o)
  );

  assign pulse_trig = |(evt & ctrl_q.src_en);
  assign level_act  = |(flags_o & ctrl_q.src_en);

  irq_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trig_i   (pulse_trig),
    .active_o (pulse_act)
  );

  assign pin_act = ctrl_q.pulse_mode ? pulse_act : level_act;

  irq_pad_drive u_pad (
    .active_i      (pin_act),
    .active_high_i (ctrl_q.active_high),
    .pin_o         (irq_o),
    .pin_oe_o      (irq_oe_o)
  );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_wdog_i,
  input logic       evt_alarm_i,
  input logic       evt_pwr_i,
  input logic       ctrl_we_i,
  input logic [4:0] ctrl_wdata_i,
  input logic [4:0] ctrl_rdata_o,
  input logic       flags_rd_i,
  input logic [2:0] flags_o,
  input logic       irq_o,
  input logic       irq_oe_o
);
  logic [2:0] ev;
  logic       pin_on;
  assign ev     = {evt_pwr_i, evt_alarm_i, evt_wdog_i};
  assign pin_on = ctrl_rdata_o[3] ? irq_o : irq_oe_o;

  p_flag_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |ev |=> ((flags_o & $past(ev)) == $past(ev)));

  p_read_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_rd_i |=> (flags_o == $past(ev)));

  p_level_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[4] && ((flags_o & ctrl_rdata_o[2:0]) == 3'b0)) |-> !pin_on);

  p_level_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[4] && ((flags_o & ctrl_rdata_o[2:0]) != 3'b0)) |-> pin_on);

  p_pulse_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[4] && !ctrl_we_i && ((ev & ctrl_rdata_o[2:0]) != 3'b0)) |=> pin_on);

  p_drive_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[3] |-> irq_oe_o);

  p_open_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[3] |-> !irq_o);

  p_ctrl_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_rdata_o == $past(ctrl_wdata_i)));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_wdog_i   (evt_wdog_i),
  .evt_alarm_i  (evt_alarm_i),
  .evt_pwr_i    (evt_pwr_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .flags_rd_i   (flags_rd_i),
  .flags_o      (flags_o),
  .irq_o        (irq_o),
  .irq_oe_o     (irq_oe_o)
);

// File: tb/irq_pin_ctrl_test.sv
`timescale 1ns/1ps
module irq_pin_ctrl_test;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_w = 0, ev_a = 0, ev_p = 0;
  logic       we = 0, rd = 0;
  logic [4:0] wdata = '0;
  logic [4:0] ctrl_rd;
  logic [2:0] flags;
  logic       irq, irq_oe;

  int checks = 0, fails = 0;
  string req = "R9";

  // reference model state
  int   m_flags = 0, m_ctrl = 0, m_cnt = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  irq_pin_ctrl #(.PULSE_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_wdog_i(ev_w), .evt_alarm_i(ev_a), .evt_pwr_i(ev_p),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_rdata_o(ctrl_rd),
    .flags_rd_i(rd), .flags_o(flags), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit asrt;
    int exp_o, exp_oe;
    asrt = ((m_ctrl >> 4) & 1) ? (m_cnt > 0) : ((m_flags & m_ctrl & 7) != 0);
    if ((m_ctrl >> 3) & 1) begin exp_o = asrt; exp_oe = 1; end
    else begin exp_o = 0; exp_oe = asrt; end
    chk("flags", flags, m_flags);
    chk("ctrl", ctrl_rd, m_ctrl);
    chk("pin", {irq, irq_oe}, exp_o * 2 + exp_oe);
  endtask

  // drive one cycle of stimulus, advance model at the edge, compare after
  task automatic step(input bit w, input bit a, input bit p, input bit r,
                      input bit wr = 0, input int wd = 0);
    int ev;
    ev_w = w; ev_a = a; ev_p = p; rd = r; we = wr; wdata = 5'(wd);
    ev = {p, a, w};
    @(posedge clk);
    if ((ev & m_ctrl & 7) != 0) m_cnt = P;
    else if (m_cnt > 0) m_cnt--;
    m_flags = (r ? 0 : m_flags) | ev;
    if (wr) m_ctrl = wd & 31;
    @(negedge clk);
    ev_w = 0; ev_a = 0; ev_p = 0; rd = 0; we = 0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R9"; compare();          // in reset: all clear, pin released
    rst_n = 1'b1;
    @(negedge clk); compare();

    req = "R1"; // disabled sources still set flags
    step(1, 0, 0, 0); step(0, 1, 0, 0); step(0, 0, 1, 0);
    req = "R3"; idle(3);
    req = "R2"; step(0, 0, 0, 1); idle(1);

    req = "R10"; step(0, 0, 0, 0, 1, 5'b00111);   // level, open drain, all enabled
    req = "R4"; step(0, 1, 0, 0); idle(2);
    req = "R8"; idle(1);
    req = "R2"; step(1, 0, 0, 1); idle(1);        // read with concurrent event
    step(0, 0, 0, 1); idle(2);
    req = "R7"; step(0, 0, 0, 0, 1, 5'b01010);    // active high, alarm only
    req = "R3"; step(1, 0, 1, 0); idle(2);
    req = "R4"; step(0, 1, 0, 0); idle(2); step(0, 0, 0, 1); idle(2);

    req = "R10"; step(0, 0, 0, 0, 1, 5'b11001);   // pulse, active high, wdog
    req = "R5"; step(1, 0, 0, 0); idle(P + 3);
    req = "R6"; step(1, 0, 0, 0); idle(4); step(1, 0, 0, 0); idle(P + 2);
    req = "R3"; step(0, 1, 1, 0); idle(3); step(0, 0, 0, 1);
    req = "R8"; step(0, 0, 0, 0, 1, 5'b10001);    // pulse, open drain
    step(1, 0, 0, 0); idle(3); step(1, 0, 0, 0); idle(P + 2);

    req = "R1";                                   // random mix against model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      step(r[0] & r[5], r[1] & r[6], r[2] & r[7], r[3] & r[8],
           (r[15:12] == 4'd0), int'(r[20:16]));
    end

    req = "R9"; rst_n = 1'b0;
    m_flags = 0; m_ctrl = 0; m_cnt = 0;
    #1 compare();
    finish_up();
  end
endmodule